// File: doc/BRIEF.md
# Memory Bus Breakpoint Comparator

This block is one hardware breakpoint channel. It watches data bus cycles and raises a break request when a cycle meets a programmed condition. The condition combines a masked address compare, an optional masked data compare, the transfer direction, the access size, the bus the cycle ran on and the access class. Instruction-fetch breaks are outside the block. Every cycle presented to it is a data access.

A channel built with `XY_CAPABLE = 1` can also move its address and data compare onto a dual X/Y memory bus. Both X and Y reference addresses share one address/mask register pair: the X value sits in the upper half and the Y value in the lower half. A select decides which half is compared. X/Y word data is always matched against the upper half of the data and data-mask registers.

A match is not reported straight away. The break pulse waits for the instruction-complete strobe. When a data compare is enabled it waits one further instruction. Each break also sets a sticky flag that software clears.

Top module: `bus_break_cmp`

## Requirements
- R1: On a main-bus cycle (`cyc_bus`=0; 1 is the internal bus, 2 the X bus, 3 the Y bus), a match needs all of the following. `cfg_bus` must admit the bus: bit0 admits main, bit1 admits internal. `cfg_access` bit1 must be set, which admits data accesses. The direction must pass `cfg_dir`: bit0 admits read, bit1 admits write. `cfg_size` must be 0 (any size) or equal to `cyc_size`+1, where `cyc_size` is 0 for byte, 1 for word and 2 for long. The address must compare equal.
- R2: The address compares equal when `((cyc_addr ^ cfg_addr) & ~cfg_amask) == 0`. A mask bit of 1 makes that bit don't-care. The data compare uses the same rule with `cfg_data`/`cfg_dmask`, limited to the low 8, 16 or 32 bits according to the cycle's size.
- R3: Without a data compare, the break pulse follows the first `insn_done` seen in a cycle after the matching cycle. With `cfg_data_en` set, it follows the second such `insn_done`. A strobe in the matching cycle itself does not count.
- R4: A cycle with `cyc_pref` set is treated as a long read whatever its `cyc_write`/`cyc_size`. While `cfg_data_en` is 1 it never produces a break.
- R5: In X/Y mode (`cfg_xy_en`=1 on a capable channel), `cfg_xy_x` selects the X bus and `cfg_xy_y` selects the Y bus. Only cycles on the selected bus match. `cyc_addr[15:0]` is compared against `cfg_addr[31:16]` under mask `cfg_amask[31:16]` for X, and against bits 15:0 of both registers for Y.
- R6: In X/Y mode the data compare takes `cyc_data[15:0]` against `cfg_data[31:16]` under mask `cfg_dmask[31:16]`. Bits 15:0 of both registers have no effect.
- R7: An X/Y configuration produces no match unless all of these hold: exactly one of `cfg_xy_x`/`cfg_xy_y` is set, `cfg_bus`=1, `cfg_access`=2, `cfg_dir`≠0, and `cfg_size` is 0 or 2.
- R8: A channel built with `XY_CAPABLE = 0` ignores `cfg_xy_en` and never matches X or Y bus cycles. A capable channel in main mode never matches them either.
- R9: `brk_o` is high for exactly one cycle per break. `flag_o` goes high together with it and stays high until a cycle with `flag_clr`. A new break in that same cycle wins.
- R10: After reset `brk_o` and `flag_o` are 0 and no match is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_bus | input | 2 | Bus id: 0 main, 1 internal, 2 X, 3 Y |
| cyc_addr | input | AW | Cycle address |
| cyc_data | input | DW | Cycle data |
| cyc_write | input | 1 | 1 write, 0 read |
| cyc_size | input | 2 | 0 byte, 1 word, 2 long |
| cyc_pref | input | 1 | Prefetch-class access |
| insn_done | input | 1 | Instruction-complete strobe |
| cfg_addr | input | AW | Reference address (X in upper half, Y in lower half in X/Y mode) |
| cfg_amask | input | AW | Address don't-care mask |
| cfg_data | input | DW | Reference data |
| cfg_dmask | input | DW | Data don't-care mask |
| cfg_bus | input | 2 | Admitted buses: bit0 main, bit1 internal |
| cfg_access | input | 2 | Admitted classes: bit0 fetch, bit1 data |
| cfg_dir | input | 2 | Admitted directions: bit0 read, bit1 write |
| cfg_size | input | 2 | 0 any, 1 byte, 2 word, 3 long |
| cfg_data_en | input | 1 | Include the data compare |
| cfg_xy_en | input | 1 | Move the compare onto the X/Y bus |
| cfg_xy_x | input | 1 | Select the X bus |
| cfg_xy_y | input | 1 | Select the Y bus |
| flag_clr | input | 1 | Clear the sticky flag |
| brk_o | output | 1 | One-cycle break request |
| flag_o | output | 1 | Sticky condition-match flag |

## Verification
The bench builds two copies with the default 32-bit address and data widths. One has `XY_CAPABLE = 1` and the other `XY_CAPABLE = 0`, and both receive the same stimulus. The capable copy reaches the X/Y half selection, the upper-half data rule and the invalid X/Y configurations. The other copy shows that the same X/Y programming and traffic are ignored. The 32-bit widths also make the halves of the registers distinct, so a swap of X and Y halves shows up at the break output.

// File: rtl/bus_break_cmp.sv
module bus_break_cmp #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit XY_CAPABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic [1:0]    cyc_bus,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_size,
  input  logic          cyc_pref,
  input  logic          insn_done,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_amask,
  input  logic [DW-1:0] cfg_data,
  input  logic [DW-1:0] cfg_dmask,
  input  logic [1:0]    cfg_bus,
  input  logic [1:0]    cfg_access,
  input  logic [1:0]    cfg_dir,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_data_en,
  input  logic          cfg_xy_en,
  input  logic          cfg_xy_x,
  input  logic          cfg_xy_y,
  input  logic          flag_clr,
  output logic          brk_o,
  output logic          flag_o
);
  localparam int AH = AW / 2;
  localparam int DH = DW / 2;

  logic          eff_wr;
  logic [1:0]    eff_sz;
  logic          dir_ok, size_ok;
  logic [DW-1:0] lane;

  assign eff_wr  = cyc_pref ? 1'b0 : cyc_write;
  assign eff_sz  = cyc_pref ? 2'd2 : cyc_size;
  assign dir_ok  = eff_wr ? cfg_dir[1] : cfg_dir[0];
  assign size_ok = (cfg_size == 2'd0) || (cfg_size == eff_sz + 2'd1);
  assign lane    = (eff_sz == 2'd0) ? DW'(8'hFF) :
                   (eff_sz == 2'd1) ? DW'(16'hFFFF) : '1;

  // main / internal bus path
  logic m_bus_ok, m_addr_ok, m_data_ok, m_hit;
  assign m_bus_ok  = (cyc_bus == 2'd0) ? cfg_bus[0] :
                     (cyc_bus == 2'd1) ? cfg_bus[1] : 1'b0;
  assign m_addr_ok = ((cyc_addr ^ cfg_addr) & ~cfg_amask) == '0;
  assign m_data_ok = !cfg_data_en ||
                     (!cyc_pref && (((cyc_data ^ cfg_data) & ~cfg_dmask & lane) == '0));
  assign m_hit     = m_bus_ok && cfg_access[1] && dir_ok && size_ok && m_addr_ok && m_data_ok;

  // X/Y bus path
  logic          xy_mode, xy_cfg_ok, xy_bus_ok, xy_addr_ok, xy_data_ok, xy_hit;
  logic [AH-1:0] xy_ref, xy_msk;
  assign xy_mode    = XY_CAPABLE && cfg_xy_en;
  assign xy_cfg_ok  = (cfg_xy_x ^ cfg_xy_y) && (cfg_bus == 2'd1) && (cfg_access == 2'd2) &&
                      (cfg_dir != 2'd0) && ((cfg_size == 2'd0) || (cfg_size == 2'd2));
  assign xy_bus_ok  = cyc_bus == (cfg_xy_x ? 2'd2 : 2'd3);
  assign xy_ref     = cfg_xy_x ? cfg_addr[AW-1:AH]  : cfg_addr[AH-1:0];
  assign xy_msk     = cfg_xy_x ? cfg_amask[AW-1:AH] : cfg_amask[AH-1:0];
  assign xy_addr_ok = ((cyc_addr[AH-1:0] ^ xy_ref) & ~xy_msk) == '0;
  assign xy_data_ok = !cfg_data_en ||
                      (!cyc_pref && (((cyc_data[DH-1:0] ^ cfg_data[DW-1:DH]) & ~cfg_dmask[DW-1:DH]) == '0));
  assign xy_hit     = xy_cfg_ok && xy_bus_ok && dir_ok && size_ok && xy_addr_ok && xy_data_ok;

  logic hit, pend, skip, fire;
  assign hit  = cyc_valid && (xy_mode ? xy_hit : m_hit);
  assign fire = pend && insn_done && !skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      skip   <= 1'b0;
      brk_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      brk_o <= fire;
      if (fire) begin
        pend <= 1'b0;
        skip <= 1'b0;
      end else if (hit && !pend) begin
        pend <= 1'b1;
        skip <= cfg_data_en;
      end else if (pend && insn_done) begin
        skip <= 1'b0;
      end
      if (fire)          flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |=> !brk_o);
  p_flag_with_brk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> flag_o);
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (brk_o || !flag_o));
  p_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_o) |-> $past(insn_done));
  p_pref_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_en && cyc_valid && cyc_pref && !pend) |=> !pend);

  generate
    if (!XY_CAPABLE) begin : g_plain
      p_no_xy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_bus[1] && !pend) |=> !pend);
    end
  endgenerate
endmodule

// File: tb/bus_break_cmp_tb_top.sv
module bus_break_cmp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cyc_valid = 0, cyc_write = 0, cyc_pref = 0, insn_done = 0;
  logic [1:0]  cyc_bus = 0, cyc_size = 0;
  logic [31:0] cyc_addr = 0, cyc_data = 0;
  logic [31:0] cfg_addr = 0, cfg_amask = 0, cfg_data = 0, cfg_dmask = 0;
  logic [1:0]  cfg_bus = 0, cfg_access = 0, cfg_dir = 0, cfg_size = 0;
  logic        cfg_data_en = 0, cfg_xy_en = 0, cfg_xy_x = 0, cfg_xy_y = 0, flag_clr = 0;
  logic        brk_b, flag_b, brk_a, flag_a;

  bus_break_cmp #(.AW(32), .DW(32), .XY_CAPABLE(1'b1)) dut_i (
    .clk, .rst_n, .cyc_valid, .cyc_bus, .cyc_addr, .cyc_data, .cyc_write, .cyc_size,
    .cyc_pref, .insn_done, .cfg_addr, .cfg_amask, .cfg_data, .cfg_dmask, .cfg_bus,
    .cfg_access, .cfg_dir, .cfg_size, .cfg_data_en, .cfg_xy_en, .cfg_xy_x, .cfg_xy_y,
    .flag_clr, .brk_o(brk_b), .flag_o(flag_b));

  bus_break_cmp #(.AW(32), .DW(32), .XY_CAPABLE(1'b0)) dut_a_i (
    .clk, .rst_n, .cyc_valid, .cyc_bus, .cyc_addr, .cyc_data, .cyc_write, .cyc_size,
    .cyc_pref, .insn_done, .cfg_addr, .cfg_amask, .cfg_data, .cfg_dmask, .cfg_bus,
    .cfg_access, .cfg_dir, .cfg_size, .cfg_data_en, .cfg_xy_en, .cfg_xy_x, .cfg_xy_y,
    .flag_clr, .brk_o(brk_a), .flag_o(flag_a));

  typedef struct packed {
    logic xe, xx, xy; logic [1:0] cb, ca, cd, cs; logic de;
    logic [31:0] ad, am, da, dm;
    logic [1:0] yb; logic [31:0] ya, yd; logic yw; logic [1:0] ys; logic yp;
    logic [1:0] ex; logic [7:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // R1 exact long read
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd1,2'd3,1'b0,32'h1000_0040,32'h0,32'h0,32'h0,2'd0,32'h1000_0040,32'h0,1'b0,2'd2,1'b0,2'd1,8'd1},
    // R1 address differs
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd1,2'd3,1'b0,32'h1000_0040,32'h0,32'h0,32'h0,2'd0,32'h1000_0044,32'h0,1'b0,2'd2,1'b0,2'd0,8'd1},
    // R1 write against read-only
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd1,2'd3,1'b0,32'h1000_0040,32'h0,32'h0,32'h0,2'd0,32'h1000_0040,32'h0,1'b1,2'd2,1'b0,2'd0,8'd1},
    // R1 word cycle against long
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd1,2'd3,1'b0,32'h1000_0040,32'h0,32'h0,32'h0,2'd0,32'h1000_0040,32'h0,1'b0,2'd1,1'b0,2'd0,8'd1},
    // R2 masked low byte
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd3,2'd0,1'b0,32'h1000_0040,32'h0000_00FF,32'h0,32'h0,2'd0,32'h1000_00A7,32'h0,1'b1,2'd0,1'b0,2'd1,8'd2},
    // R2 unmasked bit 8 differs
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd3,2'd0,1'b0,32'h1000_0040,32'h0000_00FF,32'h0,32'h0,2'd0,32'h1000_0140,32'h0,1'b1,2'd0,1'b0,2'd0,8'd2},
    // R3 data match defers a second instruction
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd3,2'd0,1'b1,32'h2000_0000,32'h0,32'h1234_5678,32'h0,2'd0,32'h2000_0000,32'h1234_5678,1'b1,2'd2,1'b0,2'd2,8'd3},
    // R3 data mismatch
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd3,2'd0,1'b1,32'h2000_0000,32'h0,32'h1234_5678,32'h0,2'd0,32'h2000_0000,32'h1234_5679,1'b1,2'd2,1'b0,2'd0,8'd3},
    // R2 byte lane compares bits 7:0 only
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd3,2'd1,1'b1,32'h2000_0000,32'h0,32'h1234_5678,32'h0,2'd0,32'h2000_0000,32'hFFFF_FF78,1'b0,2'd0,1'b0,2'd2,8'd2},
    // R4 prefetch with data compare
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd3,2'd0,1'b1,32'h3000_0000,32'h0,32'h0,32'hFFFF_FFFF,2'd0,32'h3000_0000,32'h0,1'b0,2'd2,1'b1,2'd0,8'd4},
    // R4 prefetch seen as long read
    '{1'b0,1'b0,1'b0,2'd1,2'd2,2'd1,2'd3,1'b0,32'h3000_0000,32'h0,32'h0,32'h0,2'd0,32'h3000_0000,32'h0,1'b1,2'd0,1'b1,2'd1,8'd4},
    // R5 X bus uses upper half
    '{1'b1,1'b1,1'b0,2'd1,2'd2,2'd3,2'd2,1'b0,32'h0120_0340,32'h0,32'h0,32'h0,2'd2,32'h0000_0120,32'h0,1'b0,2'd1,1'b0,2'd1,8'd5},
    // R5 Y bus uses lower half
    '{1'b1,1'b0,1'b1,2'd1,2'd2,2'd3,2'd2,1'b0,32'h0120_0340,32'h0,32'h0,32'h0,2'd3,32'h0000_0340,32'h0,1'b1,2'd1,1'b0,2'd1,8'd5},
    // R5 X selected, cycle on Y bus
    '{1'b1,1'b1,1'b0,2'd1,2'd2,2'd3,2'd2,1'b0,32'h0120_0120,32'h0,32'h0,32'h0,2'd3,32'h0000_0120,32'h0,1'b0,2'd1,1'b0,2'd0,8'd5},
    // R6 X/Y data in upper half
    '{1'b1,1'b1,1'b0,2'd1,2'd2,2'd3,2'd0,1'b1,32'h0120_0000,32'h0,32'hBEEF_0000,32'h0,2'd2,32'h0000_0120,32'h0000_BEEF,1'b0,2'd1,1'b0,2'd2,8'd6},
    // R6 lower half of data register ignored
    '{1'b1,1'b1,1'b0,2'd1,2'd2,2'd3,2'd0,1'b1,32'h0120_0000,32'h0,32'hBEEF_1234,32'h0,2'd2,32'h0000_0120,32'h0000_BEEF,1'b0,2'd1,1'b0,2'd2,8'd6},
    // R6 X/Y data mismatch
    '{1'b1,1'b1,1'b0,2'd1,2'd2,2'd3,2'd0,1'b1,32'h0120_0000,32'h0,32'hBEEF_0000,32'h0,2'd2,32'h0000_0120,32'h0000_BEEE,1'b0,2'd1,1'b0,2'd0,8'd6},
    // R7 both X and Y selected
    '{1'b1,1'b1,1'b1,2'd1,2'd2,2'd3,2'd0,1'b0,32'h0120_0120,32'h0,32'h0,32'h0,2'd2,32'h0000_0120,32'h0,1'b0,2'd1,1'b0,2'd0,8'd7},
    // R7 long size in X/Y mode
    '{1'b1,1'b1,1'b0,2'd1,2'd2,2'd3,2'd3,1'b0,32'h0120_0000,32'h0,32'h0,32'h0,2'd2,32'h0000_0120,32'h0,1'b0,2'd2,1'b0,2'd0,8'd7},
    // R7 access class not data-only
    '{1'b1,1'b1,1'b0,2'd1,2'd3,2'd3,2'd0,1'b0,32'h0120_0000,32'h0,32'h0,32'h0,2'd2,32'h0000_0120,32'h0,1'b0,2'd1,1'b0,2'd0,8'd7},
    // R8 main mode ignores X bus cycle
    '{1'b0,1'b0,1'b0,2'd3,2'd2,2'd3,2'd0,1'b0,32'h0000_0120,32'h0,32'h0,32'h0,2'd2,32'h0000_0120,32'h0,1'b0,2'd1,1'b0,2'd0,8'd8}
  };

  int total = 0, bad = 0;
  logic s1, s2, sa1, sa2, sf;

  task automatic check(input string rq, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", rq, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    cfg_xy_en = v.xe; cfg_xy_x = v.xx; cfg_xy_y = v.xy; cfg_bus = v.cb; cfg_access = v.ca;
    cfg_dir = v.cd; cfg_size = v.cs; cfg_data_en = v.de; cfg_addr = v.ad; cfg_amask = v.am;
    cfg_data = v.da; cfg_dmask = v.dm; cyc_bus = v.yb; cyc_addr = v.ya; cyc_data = v.yd;
    cyc_write = v.yw; cyc_size = v.ys; cyc_pref = v.yp;
  endtask

  task automatic run(input vec_t v);
    @(negedge clk); load(v); cyc_valid = 1; insn_done = 0;
    @(negedge clk); cyc_valid = 0; insn_done = 1;
    @(negedge clk); s1 = brk_b; sa1 = brk_a;
    @(negedge clk); s2 = brk_b; sa2 = brk_a; sf = flag_b; insn_done = 0; flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 brk after reset", brk_b, 1'b0);
    check("R10 flag after reset", flag_b, 1'b0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i]);
      check($sformatf("R%0d vec%0d first", VECS[i].rq, i), s1, VECS[i].ex == 2'd1);
      check($sformatf("R%0d vec%0d second", VECS[i].rq, i), s2, VECS[i].ex == 2'd2);
      check($sformatf("R9 vec%0d flag", i), sf, VECS[i].ex != 2'd0);
      check("R9 flag cleared", flag_b, 1'b0);
    end

    // R8: plain channel ignores the X/Y programming that the capable one uses
    run(VECS[11]);
    check("R8 capable channel breaks", s1, 1'b1);
    check("R8 plain channel first", sa1, 1'b0);
    check("R8 plain channel second", sa2, 1'b0);
    run(VECS[0]);
    check("R8 plain channel main bus", sa1, 1'b1);

    // R3: strobe in the matching cycle does not count
    @(negedge clk); load(VECS[0]); cyc_valid = 1; insn_done = 1;
    @(negedge clk); cyc_valid = 0; insn_done = 0;
    @(negedge clk); check("R3 same-cycle strobe", brk_b, 1'b0);
    insn_done = 1;
    @(negedge clk); check("R3 next strobe fires", brk_b, 1'b1); insn_done = 0;
    @(negedge clk); check("R9 pulse one cycle", brk_b, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 flag sticky", flag_b, 1'b1);
    flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    check("R9 flag clear", flag_b, 1'b0);

    // R9: break and clear in the same cycle, break wins
    @(negedge clk); load(VECS[0]); cyc_valid = 1;
    @(negedge clk); cyc_valid = 0; insn_done = 1; flag_clr = 1;
    @(negedge clk); insn_done = 0; flag_clr = 0;
    check("R9 set beats clear", flag_b, 1'b1);

    // R10: reset mid-pending drops the match
    @(negedge clk); load(VECS[6]); cyc_valid = 1;
    @(negedge clk); cyc_valid = 0; rst_n = 0;
    @(negedge clk); check("R10 flag on reset", flag_b, 1'b0); rst_n = 1; insn_done = 1;
    @(negedge clk);
    @(negedge clk); check("R10 pending dropped", brk_b, 1'b0); insn_done = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule